// File: doc/BRIEF.md
# Battery charger settings register file with host watchdog

This block holds the settings a host programs into a battery charge controller: the charge voltage limit, the charge current, the input current limit, the minimum system voltage and an option word. The host reaches them through a parallel port. Each access carries an 8-bit command code, a write strobe with 16-bit data, and a combinational read path. Each setting keeps only its legal bit field, so a written value is masked to the step its converter can resolve. The masked values go straight to the regulation loops.

A cell-count strap selects 2-cell or 3-cell defaults. The strap is sampled once, a fixed number of millisecond ticks after reset is released, and the defaults load at that moment. Before then every setting reads zero and writes are refused. A host-communication watchdog, whose period comes from two option bits, clears the charge current if the host stops rewriting the charge settings. A separate bus timer releases the port when a transaction stays open too long. A charge-enable qualifier summarises whether charging may run.

Top module: `chg_regfile`

## Requirements
- R1: Until STRAP_MS rising `tick_ms` pulses have been counted after reset, `cfg_ready` is 0, every command reads 0x0000 and writes are ignored; on the STRAP_MS-th tick `cfg_ready` rises and the defaults load.
- R2: With `cell3` high at load, the defaults are: command 0x15 (charge voltage) = 0x34C0, 0x3E (minimum system voltage) = 0x2400, 0x3F (input current) = 0x1000, 0x14 (charge current) = 0x0000, 0x12 (options) = 0x6000.
- R3: With `cell3` low at load, the charge voltage defaults to 0x2330 and the minimum system voltage defaults to 0x1800; the other defaults match R2.
- R4: Written data is masked per register. 0x15 keeps bits [14:4]. 0x14 keeps bits [12:6] (64 mA step). 0x3F keeps bits [13:7] (128 mA step). 0x3E keeps bits [13:8]. 0x12 keeps all 16 bits. A 0xFFFF write therefore reads back as 0x7FF0, 0x1FC0, 0x3F80, 0x3F00 and 0xFFFF.
- R5: Any command other than 0x12, 0x14, 0x15, 0x3E and 0x3F reads 0x0000, and a write to it changes no register.
- R6: Option bits [14:13] select the watchdog period in ticks counted since the last restart: 00 disables it, 01 selects WD_P1, 10 selects WD_P2 and 11 selects WD_P3.
- R7: When the watchdog expires, the charge current reads 0x0000 and `wd_expired` is 1. An accepted write to 0x14 or 0x15 restarts the count and clears `wd_expired`.
- R8: When `txn_active` stays high for BUS_TMO_MS ticks, `bus_release` goes to 1. While it is 1, writes are ignored. It returns to 0 one cycle after `txn_active` goes low.
- R9: `chg_ok` is 1 exactly when `cfg_ready` is 1, `wd_expired` is 0, and both the charge current and the charge voltage are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| cell3 | input | 1 | Cell-count strap, 1 = 3-cell, 0 = 2-cell |
| txn_active | input | 1 | High while a host transaction is open |
| wr_en | input | 1 | Write strobe, one cycle per write |
| cmd | input | 8 | Command code for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Masked content of the addressed register |
| vchg_set | output | 16 | Charge voltage setting |
| ichg_set | output | 16 | Charge current setting |
| iin_set | output | 16 | Input current setting |
| vsys_set | output | 16 | Minimum system voltage setting |
| opt_set | output | 16 | Option word |
| cfg_ready | output | 1 | Defaults loaded, port open |
| wd_expired | output | 1 | Watchdog has expired |
| bus_release | output | 1 | Transaction timed out, port released |
| chg_ok | output | 1 | Charge-enable qualifier |

## Verification
The assertions assume three things about the inputs. `rst_n` is low from time zero. `tick_ms` is a one-cycle pulse. `wr_en` lasts a single cycle with `cmd` and `wdata` steady around it. The stimulus meets these by driving every input on the falling clock edge. Ticks are single high cycles separated by a low cycle. Each write is a one-cycle strobe. `cell3` is set before reset and held until after the defaults load. Reads apply a command and sample the combinational `rdata` within the same low clock phase.

// File: rtl/chg_regfile.sv
module chg_regfile #(
  parameter int STRAP_MS   = 100,
  parameter int BUS_TMO_MS = 30,
  parameter int WD_P1      = 44000,
  parameter int WD_P2      = 88000,
  parameter int WD_P3      = 175000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_ms,
  input  logic        cell3,
  input  logic        txn_active,
  input  logic        wr_en,
  input  logic [7:0]  cmd,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic [15:0] vchg_set,
  output logic [15:0] ichg_set,
  output logic [15:0] iin_set,
  output logic [15:0] vsys_set,
  output logic [15:0] opt_set,
  output logic        cfg_ready,
  output logic        wd_expired,
  output logic        bus_release,
  output logic        chg_ok
);
  localparam int SW = $clog2(STRAP_MS + 1);
  localparam int BW = $clog2(BUS_TMO_MS + 1);
  localparam int WW = $clog2(WD_P3 + 1);

  localparam logic [7:0] A_OPT = 8'h12, A_ICHG = 8'h14, A_VCHG = 8'h15,
                         A_VSYS = 8'h3E, A_IIN = 8'h3F;
  localparam logic [15:0] M_VCHG = 16'h7FF0, M_ICHG = 16'h1FC0,
                          M_IIN = 16'h3F80, M_VSYS = 16'h3F00;

  logic [SW-1:0] scnt;
  logic [BW-1:0] bcnt;
  logic [WW-1:0] wcnt, wd_lim;

  wire wr_ok   = wr_en & cfg_ready & ~bus_release;
  wire wd_kick = wr_ok & (cmd == A_VCHG || cmd == A_ICHG);
  wire wd_on   = cfg_ready & (opt_set[14:13] != 2'b00) & ~wd_expired;

  always_comb
    case (opt_set[14:13])
      2'b01:   wd_lim = WW'(WD_P1);
      2'b10:   wd_lim = WW'(WD_P2);
      default: wd_lim = WW'(WD_P3);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scnt <= '0; cfg_ready <= 1'b0; wcnt <= '0; wd_expired <= 1'b0;
      vchg_set <= '0; ichg_set <= '0; iin_set <= '0; vsys_set <= '0; opt_set <= '0;
    end else if (!cfg_ready) begin
      if (tick_ms) begin
        if (scnt == SW'(STRAP_MS - 1)) begin
          cfg_ready <= 1'b1;
          vchg_set  <= cell3 ? 16'h34C0 : 16'h2330;
          vsys_set  <= cell3 ? 16'h2400 : 16'h1800;
          iin_set   <= 16'h1000;
          ichg_set  <= 16'h0000;
          opt_set   <= 16'h6000;
        end else scnt <= scnt + 1'b1;
      end
    end else begin
      if (wr_ok)
        case (cmd)
          A_VCHG: vchg_set <= wdata & M_VCHG;
          A_ICHG: ichg_set <= wdata & M_ICHG;
          A_IIN:  iin_set  <= wdata & M_IIN;
          A_VSYS: vsys_set <= wdata & M_VSYS;
          A_OPT:  opt_set  <= wdata;
          default: ;
        endcase
      if (wd_kick) begin
        wcnt <= '0; wd_expired <= 1'b0;
      end else if (wd_on && tick_ms) begin
        if (wcnt >= wd_lim - WW'(1)) begin
          wd_expired <= 1'b1; ichg_set <= '0; wcnt <= '0;
        end else wcnt <= wcnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bcnt <= '0; bus_release <= 1'b0;
    end else if (!txn_active) begin
      bcnt <= '0; bus_release <= 1'b0;
    end else if (tick_ms && !bus_release) begin
      if (bcnt == BW'(BUS_TMO_MS - 1)) bus_release <= 1'b1;
      else bcnt <= bcnt + 1'b1;
    end

  always_comb
    case (cmd)
      A_VCHG:  rdata = vchg_set;
      A_ICHG:  rdata = ichg_set;
      A_IIN:   rdata = iin_set;
      A_VSYS:  rdata = vsys_set;
      A_OPT:   rdata = opt_set;
      default: rdata = 16'h0000;
    endcase

  assign chg_ok = cfg_ready & ~wd_expired & (ichg_set != 0) & (vchg_set != 0);

  // R1
  not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ready |-> (rdata == 16'h0000 && !chg_ok));
  // R2
  load_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_ready) |-> (vchg_set == 16'h34C0 || vchg_set == 16'h2330) && ichg_set == 16'h0000);
  // R7
  expired_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired |-> (ichg_set == 16'h0000 && !chg_ok));
  // R8
  release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ready && bus_release) |=> $stable({vchg_set, iin_set, vsys_set, opt_set}));
  // R8
  release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_active |=> !bus_release);
endmodule

// File: tb/sim_chg_regfile.sv
module sim_chg_regfile;
  logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0, cell3 = 1'b1, txn_active = 1'b0, wr_en = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata, vchg_set, ichg_set, iin_set, vsys_set, opt_set;
  logic cfg_ready, wd_expired, bus_release, chg_ok;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chg_regfile #(.STRAP_MS(10), .BUS_TMO_MS(30), .WD_P1(20), .WD_P2(40), .WD_P3(80)) u0 (
    .clk, .rst_n, .tick_ms, .cell3, .txn_active, .wr_en, .cmd, .wdata, .rdata,
    .vchg_set, .ichg_set, .iin_set, .vsys_set, .opt_set,
    .cfg_ready, .wd_expired, .bus_release, .chg_ok);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic wr(logic [7:0] c, logic [15:0] d);
    @(negedge clk) begin cmd = c; wdata = d; wr_en = 1'b1; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] c, logic [15:0] exp);
    @(negedge clk) cmd = c;
    #0.5 check(req, rdata, exp);
  endtask

  task automatic do_reset(logic c3);
    @(negedge clk) begin rst_n = 1'b0; cell3 = c3; end
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_strap3;
    do_reset(1'b1);
    check("R1 ready low", {15'd0, cfg_ready}, 16'd0);
    wr(8'h15, 16'h1230);
    ticks(9);
    rd_chk("R1 vchg before load", 8'h15, 16'h0000);
    check("R1 chg_ok low", {15'd0, chg_ok}, 16'd0);
    ticks(1);
    check("R1 ready", {15'd0, cfg_ready}, 16'd1);
    rd_chk("R2 vchg", 8'h15, 16'h34C0);
    rd_chk("R2 vsys", 8'h3E, 16'h2400);
    rd_chk("R2 iin", 8'h3F, 16'h1000);
    rd_chk("R2 ichg", 8'h14, 16'h0000);
    rd_chk("R2 opt", 8'h12, 16'h6000);
    check("R9 no current", {15'd0, chg_ok}, 16'd0);
  endtask

  task automatic t_masks;
    wr(8'h15, 16'hFFFF); rd_chk("R4 vchg", 8'h15, 16'h7FF0);
    wr(8'h14, 16'hFFFF); rd_chk("R4 ichg", 8'h14, 16'h1FC0);
    wr(8'h3F, 16'hFFFF); rd_chk("R4 iin", 8'h3F, 16'h3F80);
    wr(8'h3E, 16'hFFFF); rd_chk("R4 vsys", 8'h3E, 16'h3F00);
    wr(8'h12, 16'hFFFF); rd_chk("R4 opt", 8'h12, 16'hFFFF);
    check("R9 charge ok", {15'd0, chg_ok}, 16'd1);
  endtask

  task automatic t_unmapped;
    wr(8'h20, 16'hFFFF);
    rd_chk("R5 read 0x20", 8'h20, 16'h0000);
    wr(8'h16, 16'h0000);
    rd_chk("R5 vchg kept", 8'h15, 16'h7FF0);
    rd_chk("R5 ichg kept", 8'h14, 16'h1FC0);
    rd_chk("R5 opt kept", 8'h12, 16'hFFFF);
  endtask

  task automatic t_watchdog;
    wr(8'h12, 16'h2000);
    wr(8'h14, 16'h0800);
    ticks(19);
    check("R6 p1 not yet", {15'd0, wd_expired}, 16'd0);
    rd_chk("R7 ichg held", 8'h14, 16'h0800);
    ticks(1);
    check("R7 expired", {15'd0, wd_expired}, 16'd1);
    rd_chk("R7 ichg cleared", 8'h14, 16'h0000);
    check("R9 off on expiry", {15'd0, chg_ok}, 16'd0);
    wr(8'h14, 16'h0400);
    check("R7 flag cleared", {15'd0, wd_expired}, 16'd0);
    check("R9 back on", {15'd0, chg_ok}, 16'd1);
    wr(8'h12, 16'h4000);
    wr(8'h15, 16'h3000);
    ticks(39);
    check("R6 p2 not yet", {15'd0, wd_expired}, 16'd0);
    ticks(1);
    check("R6 p2 expired", {15'd0, wd_expired}, 16'd1);
    wr(8'h12, 16'h0000);
    wr(8'h14, 16'h0400);
    ticks(200);
    check("R6 disabled", {15'd0, wd_expired}, 16'd0);
    rd_chk("R6 ichg kept", 8'h14, 16'h0400);
  endtask

  task automatic t_bus;
    @(negedge clk) txn_active = 1'b1;
    ticks(29);
    check("R8 not yet", {15'd0, bus_release}, 16'd0);
    ticks(1);
    check("R8 released", {15'd0, bus_release}, 16'd1);
    wr(8'h15, 16'h2000);
    rd_chk("R8 write ignored", 8'h15, 16'h3000);
    @(negedge clk) txn_active = 1'b0;
    @(negedge clk);
    check("R8 release drops", {15'd0, bus_release}, 16'd0);
    wr(8'h15, 16'h2000);
    rd_chk("R8 write accepted", 8'h15, 16'h2000);
  endtask

  task automatic t_strap2;
    do_reset(1'b0);
    rd_chk("R1 zero after reset", 8'h3E, 16'h0000);
    ticks(10);
    @(negedge clk) cell3 = 1'b1;
    rd_chk("R3 vchg", 8'h15, 16'h2330);
    rd_chk("R3 vsys", 8'h3E, 16'h1800);
    rd_chk("R3 iin", 8'h3F, 16'h1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_strap3();
    t_masks();
    t_unmapped();
    t_watchdog();
    t_bus();
    t_strap2();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog timeout actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule